// File: doc/BRIEF.md
# Watchdog Timer with Gated Reset Output

This peripheral guards a system against stalled software. A 32-bit down-counter, clocked by the peripheral clock, is loaded over a simple register bus and counts toward zero while its enable bit is set. Software keeps the system alive by rewriting the count before it runs out. When the count falls to zero, an expiry flag is raised in an event register. That flag drives an interrupt request through an interrupt mask and, separately, a reset output through a reset-gate mask.

The event register is cleared by writing zero. Software can therefore clear the expiry flag with a word that has every other bit set, and no other pending event is lost. Turning off the enable freezes the counter at its present value. Reading the count register gives the cycles that remain, so software can work out how much time is left. Registers: control at 0x00 (enable at bit 4), count at 0x24, event at 0x30 (expiry at bit 3), reset gate at 0x34 (bit 1), interrupt mask at 0x38 (all 32 bits).

Top module: `wdog_rstgate`

## Requirements
- R1: After an active-low asynchronous reset, every register reads zero, the counter is stopped, and `irq_o` and `rst_out_o` are low.
- R2: The control register at offset 0x00 stores only bit 4, the counter enable. A write sets it from wdata bit 4, and the other bits read 0.
- R3: A write to the count register at offset 0x24 loads wdata on the next clock edge. This load takes priority over the decrement, and a load made in the cycle the count would reach zero prevents the expiry.
- R4: While enabled, the count drops by exactly one per clock. While disabled, it keeps its value. A read of offset 0x24 returns the current count.
- R5: When the enabled count steps from 1 to 0, bit 3 of the event register at offset 0x30 is set on that same edge. The count then stays at 0 until it is reloaded.
- R6: A write to the event register clears each bit written as 0. Each bit written as 1 keeps its value.
- R7: When an expiry and a write of 0 to event bit 3 fall in the same cycle, bit 3 ends up set.
- R8: `rst_out_o` is high exactly when event bit 3 is set and bit 1 of the reset-gate register at offset 0x34 is set. That register stores only bit 1.
- R9: `irq_o` is the OR over all bits of the event register ANDed with the 32-bit interrupt mask register at offset 0x38, which reads back as written.
- R10: A count of 0xFFFFFFFF loads in full and decrements without wrapping.
- R11: `bus_rdata` is zero while `bus_rd` is low and for unmapped offsets. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_rd | input | 1 | Read strobe, data returned combinationally |
| bus_rdata | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request |
| rst_out_o | output | 1 | Gated reset output |

## Verification
The checker watches every cycle for these rules: the count moves by exactly one only while enabled and holds otherwise, zero holds until a load, a load lands on the next edge, an expiry always sets the event flag even when a clearing write lands with it, bits written as one survive, and neither output rises without the event flag and its mask. The bench's scenarios are what show the absolute register values: the reset contents, the bits that are stored in each register, the full-range count, and that a reload in the last cycle stops the expiry. They also show that a masked expiry leaves the reset output low and that unmapped accesses change nothing, which it confirms by reading the state back afterwards.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW = 32;

  localparam logic [31:0] OFS_CTRL    = 32'h0000_0000;
  localparam logic [31:0] OFS_COUNT   = 32'h0000_0024;
  localparam logic [31:0] OFS_EVENT   = 32'h0000_0030;
  localparam logic [31:0] OFS_RSTGATE = 32'h0000_0034;
  localparam logic [31:0] OFS_IRQMASK = 32'h0000_0038;

  localparam int EN_BIT     = 4;
  localparam int EXPIRE_BIT = 3;
  localparam int GATE_BIT   = 1;

  // one step of the counter: floor at zero
  function automatic logic [DW-1:0] count_step(input logic [DW-1:0] cur);
    return (cur == '0) ? cur : cur - DW'(1);
  endfunction

  // write-zero-to-clear merge of one register word
  function automatic logic [DW-1:0] w0c_merge(input logic [DW-1:0] old,
                                              input logic [DW-1:0] wd,
                                              input logic          wr);
    return wr ? (old & wd) : old;
  endfunction
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] count_i,
  input  logic [DW-1:0] event_i,
  output logic          enable_o,
  output logic          gate_o,
  output logic [DW-1:0] imask_o,
  output logic          load_o,
  output logic          event_wr_o,
  output logic [DW-1:0] rdata_o
);
  logic hit_ctrl, hit_count, hit_event, hit_gate, hit_imask;

  assign hit_ctrl  = (addr == AW'(OFS_CTRL));
  assign hit_count = (addr == AW'(OFS_COUNT));
  assign hit_event = (addr == AW'(OFS_EVENT));
  assign hit_gate  = (addr == AW'(OFS_RSTGATE));
  assign hit_imask = (addr == AW'(OFS_IRQMASK));

  assign load_o     = wr & hit_count;
  assign event_wr_o = wr & hit_event;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_o <= 1'b0;
      gate_o   <= 1'b0;
      imask_o  <= '0;
    end else if (wr) begin
      if (hit_ctrl)  enable_o <= wdata[EN_BIT];
      if (hit_gate)  gate_o   <= wdata[GATE_BIT];
      if (hit_imask) imask_o  <= wdata;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (hit_ctrl)  rdata_o[EN_BIT]   = enable_o;
      if (hit_count) rdata_o           = count_i;
      if (hit_event) rdata_o           = event_i;
      if (hit_gate)  rdata_o[GATE_BIT] = gate_o;
      if (hit_imask) rdata_o           = imask_o;
    end
  end
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt
  import wdog_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  output logic [DW-1:0] count_o,
  output logic          expire_o
);
  logic at_one;

  assign at_one   = (count_o == DW'(1));
  assign expire_o = enable_i & at_one & ~load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_o <= '0;
    else if (load_i)   count_o <= load_val_i;
    else if (enable_i) count_o <= count_step(count_o);
  end
endmodule

// File: rtl/wdog_event.sv
module wdog_event
  import wdog_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] imask_i,
  input  logic          gate_i,
  output logic [DW-1:0] event_o,
  output logic          irq_o,
  output logic          rst_out_o
);
  logic [DW-1:0] kept;

  assign kept = w0c_merge(event_o, wdata_i, wr_i);

  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) event_o[i] <= 1'b0;
      else        event_o[i] <= set_i[i] | kept[i];
    end
  end

  assign irq_o     = |(event_o & imask_i);
  assign rst_out_o = event_o[EXPIRE_BIT] & gate_i;
endmodule

// File: rtl/wdog_rstgate.sv
module wdog_rstgate
  import wdog_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o,
  output logic          rst_out_o
);
  logic          enable_q;
  logic          gate_q;
  logic [DW-1:0] imask_q;
  logic          load;
  logic          event_wr;
  logic [DW-1:0] count_q;
  logic          expire;
  logic [DW-1:0] event_q;
  logic [DW-1:0] event_set;

  assign event_set = DW'(expire) << EXPIRE_BIT;

  wdog_regfile #(.AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .count_i    (count_q),
    .event_i    (event_q),
    .enable_o   (enable_q),
    .gate_o     (gate_q),
    .imask_o    (imask_q),
    .load_o     (load),
    .event_wr_o (event_wr),
    .rdata_o    (bus_rdata)
  );

  wdog_downcnt u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_q),
    .load_i     (load),
    .load_val_i (bus_wdata),
    .count_o    (count_q),
    .expire_o   (expire)
  );

  wdog_event u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (event_set),
    .wr_i      (event_wr),
    .wdata_i   (bus_wdata),
    .imask_i   (imask_q),
    .gate_i    (gate_q),
    .event_o   (event_q),
    .irq_o     (irq_o),
    .rst_out_o (rst_out_o)
  );
endmodule

// File: rtl/wdog_rstgate_chk.sv
module wdog_rstgate_chk
  import wdog_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] wdata,
  input logic          enable,
  input logic          load,
  input logic          event_wr,
  input logic [DW-1:0] count,
  input logic          expire,
  input logic          expired_bit,
  input logic          gate,
  input logic          irq,
  input logic          rst_out
);
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(wdata));

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load) |=> $stable(count));

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !load && count != '0) |=> count == $past(count) - DW'(1));

  p_zero_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load) |=> count == '0);

  p_expire_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (expired_bit && count == '0));

  p_ones_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (event_wr && wdata[EXPIRE_BIT] && expired_bit) |=> expired_bit);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && event_wr && !wdata[EXPIRE_BIT]) |=> expired_bit);

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> (expired_bit && gate));

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !expired_bit) |-> 1'b0);
endmodule

bind wdog_rstgate wdog_rstgate_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wdata       (bus_wdata),
  .enable      (enable_q),
  .load        (load),
  .event_wr    (event_wr),
  .count       (count_q),
  .expire      (expire),
  .expired_bit (event_q[3]),
  .gate        (gate_q),
  .irq         (irq_o),
  .rst_out     (rst_out_o)
);

// File: tb/wdog_rstgate_tb_top.sv
module wdog_rstgate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        rst_out_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  wdog_rstgate dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .rst_out_o (rst_out_o)
  );

  // behavioural reference state
  bit [31:0] m_cnt, m_event, m_imask;
  bit        m_en, m_gate;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] ref_read(input bit [31:0] a);
    case (a)
      32'h00:  return m_en ? 32'h10 : 32'h0;
      32'h24:  return m_cnt;
      32'h30:  return m_event;
      32'h34:  return m_gate ? 32'h2 : 32'h0;
      32'h38:  return m_imask;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit fire;
    bit wr_cnt;
    if (!rst_n) begin
      m_cnt = 0; m_event = 0; m_imask = 0; m_en = 0; m_gate = 0;
    end else begin
      wr_cnt = bus_wr && bus_addr == 32'h24;
      fire = m_en && m_cnt == 1 && !wr_cnt;
      if (bus_wr && bus_addr == 32'h30) m_event = m_event & bus_wdata;
      if (fire) m_event[3] = 1'b1;
      if (wr_cnt) m_cnt = bus_wdata;
      else if (m_en && m_cnt != 0) m_cnt = m_cnt - 1;
      if (bus_wr && bus_addr == 32'h00) m_en = bus_wdata[4];
      if (bus_wr && bus_addr == 32'h34) m_gate = bus_wdata[1];
      if (bus_wr && bus_addr == 32'h38) m_imask = bus_wdata;
    end
    #3;
    chk("R11 R4 rdata vs model", bus_rdata, bus_rd ? ref_read(bus_addr) : 32'h0);
    chk("R9 irq vs model", {31'b0, irq_o}, {31'b0, |(m_event & m_imask)});
    chk("R8 rst_out vs model", {31'b0, rst_out_o}, {31'b0, m_event[3] & m_gate});
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_get(input logic [31:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd_get(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_last_step;
    @(negedge clk);
    while (!(m_en && m_cnt == 1)) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v1, v2;
    idle(3);
    rst_n = 1'b1;

    // R1 reset contents
    rd_chk(32'h00, 32'h0, "R1 ctrl after reset");
    rd_chk(32'h24, 32'h0, "R1 count after reset");
    rd_chk(32'h30, 32'h0, "R1 event after reset");
    rd_chk(32'h34, 32'h0, "R1 gate after reset");
    rd_chk(32'h38, 32'h0, "R1 imask after reset");
    chk("R1 outputs low", {30'b0, irq_o, rst_out_o}, 32'h0);

    // R2 only enable bit stored
    wr(32'h00, 32'hFFFF_FFFF);
    rd_chk(32'h00, 32'h10, "R2 ctrl keeps only bit 4");
    wr(32'h00, 32'h0);
    rd_chk(32'h00, 32'h0, "R2 ctrl cleared");

    // R3/R4 load while disabled, hold
    wr(32'h24, 32'd100);
    rd_chk(32'h24, 32'd100, "R3 load value");
    idle(5);
    rd_chk(32'h24, 32'd100, "R4 disabled hold");

    // R4 count while enabled, freeze when disabled
    wr(32'h00, 32'h10);
    idle(10);
    wr(32'h00, 32'h0);
    rd_get(32'h24, v1);
    idle(5);
    rd_get(32'h24, v2);
    chk("R4 frozen value stable", v2, v1);
    chk("R4 counted down", {31'b0, v1 < 32'd100}, 32'h1);

    // R11 unmapped offset
    wr(32'h08, 32'hFFFF_FFFF);
    rd_chk(32'h08, 32'h0, "R11 unmapped reads zero");
    rd_chk(32'h00, 32'h0, "R11 ctrl untouched");
    rd_chk(32'h24, v1, "R11 count untouched");

    // R5/R8/R9 expiry with gate off, then on
    wr(32'h38, 32'hA5A5_0008);
    rd_chk(32'h38, 32'hA5A5_0008, "R9 imask readback");
    wr(32'h24, 32'd5);
    wr(32'h00, 32'h10);
    idle(12);
    rd_chk(32'h30, 32'h8, "R5 expiry flag set");
    rd_chk(32'h24, 32'h0, "R5 count stays at zero");
    chk("R9 irq on expiry", {31'b0, irq_o}, 32'h1);
    chk("R8 reset gated off", {31'b0, rst_out_o}, 32'h0);
    wr(32'h34, 32'hFFFF_FFFF);
    rd_chk(32'h34, 32'h2, "R8 gate keeps only bit 1");
    chk("R8 reset asserted", {31'b0, rst_out_o}, 32'h1);

    // R6 write-zero-to-clear
    wr(32'h30, 32'hFFFF_FFFF);
    rd_chk(32'h30, 32'h8, "R6 ones keep flag");
    wr(32'h38, 32'h0);
    chk("R9 irq masked", {31'b0, irq_o}, 32'h0);
    wr(32'h38, 32'h8);
    wr(32'h30, 32'hFFFF_FFF7);
    rd_chk(32'h30, 32'h0, "R6 zero clears flag");
    chk("R8 reset released", {31'b0, rst_out_o}, 32'h0);

    // R7 set beats clear in the same cycle
    wr(32'h24, 32'd4);
    wait_last_step();
    bus_wr = 1'b1; bus_addr = 32'h30; bus_wdata = 32'h0;
    @(negedge clk);
    bus_wr = 1'b0;
    rd_chk(32'h30, 32'h8, "R7 set wins");
    wr(32'h30, 32'h0);

    // R3 reload in last cycle prevents expiry
    wr(32'h24, 32'd4);
    wait_last_step();
    bus_wr = 1'b1; bus_addr = 32'h24; bus_wdata = 32'd50;
    @(negedge clk);
    bus_wr = 1'b0;
    rd_chk(32'h30, 32'h0, "R3 reload beats expiry");
    wr(32'h00, 32'h0);

    // R10 full range
    wr(32'h24, 32'hFFFF_FFFF);
    rd_chk(32'h24, 32'hFFFF_FFFF, "R10 full count loads");
    wr(32'h00, 32'h10);
    idle(6);
    rd_get(32'h24, v1);
    chk("R10 decrements without wrap", {31'b0, v1 < 32'hFFFF_FFFF && v1 > 32'hFFFF_FF00}, 32'h1);
    wr(32'h00, 32'h0);

    idle(3);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule